// File: doc/BRIEF.md
# Instruction Cache Invalidation Controller

This block is the control and status unit of a small instruction cache. It decodes a 32-bit register port with four registers: identification, memory size, control/status and invalidate-all. Reads are combinational and writes take effect at the clock edge, with no wait states. A sequencer clears the valid bit of every line in the tag array, one line per clock, whenever a whole-cache invalidate is requested.

Three events request an invalidate: leaving reset, a write that flips the enable bit, and any write to the invalidate-all register. While a sweep runs, the read-only ready flag is low. The fetch path is then told to bypass the cache array, and refill writes into the array are blocked. Bypass also holds whenever the enable bit is 0, so fetched lines then reach only the line fill buffer.

The sequencer has two states. SW_CLEAR steps a line index from 0 up to NUM_LINES-1 and clears one valid bit each cycle. SW_READY idles with ready high. There are four transitions:
- reset enters SW_CLEAR at line 0.
- SW_CLEAR goes to SW_READY on the cycle its last line is cleared.
- SW_READY returns to SW_CLEAR on a request.
- a request inside SW_CLEAR restarts the sweep at line 0.

Top module: `icache_ctl`

## Requirements
- R1: Offset 0x000 reads the identification word: bits 5:0 hold REL_NUM, bits 9:6 hold PART_NUM, bits 15:10 hold CACHE_ID, and all other bits are 0. Writes to this offset change nothing and start no sweep.
- R2: Offset 0x004 reads CACHE_KB in bits 15:0 and MEM_UNITS (in 128 KB units) in bits 31:16. The register is read-only.
- R3: Offset 0x100 reads the enable bit at bit 0 and the ready flag at bit 16, with all other bits 0. Only bit 0 is writable. The enable bit resets to 0.
- R4: Offset 0x700 and every unmapped offset read as 0.
- R5: Reset puts the sequencer in SW_CLEAR at line 0 with ready low. It then asserts the clear strobe with indices 0, 1, … NUM_LINES-1 on consecutive cycles. Ready rises in the cycle after index NUM_LINES-1 and stays high until the next request.
- R6: A write to 0x100 whose bit 0 differs from the current enable bit starts a sweep. Ready is low and the clear index is 0 in the cycle after the write. A write to 0x100 that keeps the same enable value starts nothing.
- R7: A write of any data to 0x700 starts a sweep: after the write, ready is low and the clear index is 0.
- R8: A request made while a sweep is running restarts it at index 0, and ready stays low.
- R9: The bypass output is 1 whenever the enable bit is 0 or ready is 0, and 0 otherwise.
- R10: The array write-enable equals the refill write request when bypass is 0, and is 0 when bypass is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 1 | Register access strobe |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 12 | Byte offset in the 4 KB register window |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data (combinational from reg_addr) |
| clr_en | output | 1 | Valid-bit clear strobe to the tag array |
| clr_idx | output | $clog2(NUM_LINES) | Line whose valid bit is cleared |
| refill_we_in | input | 1 | Array write request from the refill path |
| array_we | output | 1 | Gated array write enable |
| bypass | output | 1 | Serve fetch from fill buffer / main memory |

## Verification
The read path is driven with a table that covers every mapped offset plus unmapped offsets near and far from them. This table tells a correct field layout apart from a shifted or misdecoded one. Sweeps are started by reset, by an enable flip, by an invalidate write, and by a request made mid-sweep. The clear index is followed line by line, which separates a correct step-and-finish from an early or late ready and from a failed restart. Writes that keep the enable bit unchanged and writes to the read-only identification register show that only the intended events start a sweep. Bypass and array write gating are sampled in all four combinations of enable and ready.

// File: rtl/icache_ctl_pkg.sv
package icache_ctl_pkg;
    typedef enum logic {
        SW_READY = 1'b0,
        SW_CLEAR = 1'b1
    } sweep_state_e;

    localparam logic [11:0] OFS_IDENT = 12'h000;
    localparam logic [11:0] OFS_SIZE  = 12'h004;
    localparam logic [11:0] OFS_CTRL  = 12'h100;
    localparam logic [11:0] OFS_FLUSH = 12'h700;

    localparam int EN_BIT    = 0;
    localparam int READY_BIT = 16;
endpackage

// File: rtl/icache_ctl_regs.sv
module icache_ctl_regs
    import icache_ctl_pkg::*;
#(
    parameter logic [5:0]  REL_NUM   = 6'd3,
    parameter logic [3:0]  PART_NUM  = 4'd2,
    parameter logic [5:0]  CACHE_ID  = 6'd5,
    parameter logic [15:0] CACHE_KB  = 16'd8,
    parameter logic [15:0] MEM_UNITS = 16'd4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sel,
    input  logic        wr,
    input  logic [11:0] addr,
    input  logic [31:0] wdata,
    input  logic        ready,
    output logic [31:0] rdata,
    output logic        en,
    output logic        inv_req
);
    localparam logic [31:0] IDENT_WORD = {16'd0, CACHE_ID, PART_NUM, REL_NUM};
    localparam logic [31:0] SIZE_WORD  = {MEM_UNITS, CACHE_KB};

    logic wr_ctrl, wr_flush;

    assign wr_ctrl  = sel && wr && (addr == OFS_CTRL);
    assign wr_flush = sel && wr && (addr == OFS_FLUSH);
    assign inv_req  = wr_flush || (wr_ctrl && (wdata[EN_BIT] != en));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            en <= 1'b0;
        else if (wr_ctrl)
            en <= wdata[EN_BIT];
    end

    always_comb begin
        rdata = '0;
        unique case (addr)
            OFS_IDENT: rdata = IDENT_WORD;
            OFS_SIZE:  rdata = SIZE_WORD;
            OFS_CTRL: begin
                rdata[EN_BIT]    = en;
                rdata[READY_BIT] = ready;
            end
            default:   rdata = '0;
        endcase
    end
endmodule

// File: rtl/icache_ctl_sweep.sv
module icache_ctl_sweep
    import icache_ctl_pkg::*;
#(
    parameter int NUM_LINES = 64,
    localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inv_req,
    output logic             ready,
    output logic             clr_en,
    output logic [IDX_W-1:0] clr_idx
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_LINES - 1);

    sweep_state_e     state_q, state_d;
    logic [IDX_W-1:0] idx_q, idx_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SW_CLEAR;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        unique case (state_q)
            SW_READY: begin
                if (inv_req) begin
                    state_d = SW_CLEAR;
                    idx_d   = '0;
                end
            end
            SW_CLEAR: begin
                if (inv_req) begin
                    idx_d = '0;
                end else if (idx_q == LAST_IDX) begin
                    state_d = SW_READY;
                    idx_d   = '0;
                end else begin
                    idx_d = idx_q + 1'b1;
                end
            end
            default: begin
                state_d = SW_CLEAR;
                idx_d   = '0;
            end
        endcase
    end

    always_comb begin
        clr_en  = (state_q == SW_CLEAR);
        clr_idx = idx_q;
        ready   = (state_q == SW_READY);
    end

    // R5: the sweep advances one line per cycle
    p_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && !inv_req && clr_idx != LAST_IDX) |=> (clr_en && clr_idx == $past(clr_idx) + 1'b1));
    // R5: ready rises the cycle after the last line
    p_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && !inv_req && clr_idx == LAST_IDX) |=> ready);
    // R5: ready holds without a request
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !inv_req) |=> ready);
    // R8: any request (re)starts at line 0
    p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        inv_req |=> (clr_en && !ready && clr_idx == '0));
endmodule

// File: rtl/icache_ctl.sv
module icache_ctl
    import icache_ctl_pkg::*;
#(
    parameter int          NUM_LINES = 64,
    parameter logic [5:0]  REL_NUM   = 6'd3,
    parameter logic [3:0]  PART_NUM  = 4'd2,
    parameter logic [5:0]  CACHE_ID  = 6'd5,
    parameter logic [15:0] CACHE_KB  = 16'd8,
    parameter logic [15:0] MEM_UNITS = 16'd4,
    localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_sel,
    input  logic             reg_wr,
    input  logic [11:0]      reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    output logic             clr_en,
    output logic [IDX_W-1:0] clr_idx,
    input  logic             refill_we_in,
    output logic             array_we,
    output logic             bypass
);
    logic en, ready, inv_req;

    icache_ctl_regs #(
        .REL_NUM  (REL_NUM),
        .PART_NUM (PART_NUM),
        .CACHE_ID (CACHE_ID),
        .CACHE_KB (CACHE_KB),
        .MEM_UNITS(MEM_UNITS)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel    (reg_sel),
        .wr     (reg_wr),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .ready  (ready),
        .rdata  (reg_rdata),
        .en     (en),
        .inv_req(inv_req)
    );

    icache_ctl_sweep #(
        .NUM_LINES(NUM_LINES)
    ) u_sweep (
        .clk    (clk),
        .rst_n  (rst_n),
        .inv_req(inv_req),
        .ready  (ready),
        .clr_en (clr_en),
        .clr_idx(clr_idx)
    );

    always_comb begin
        bypass   = !en || !ready;
        array_we = refill_we_in && !bypass;
    end

    // R6: flipping the enable bit drops ready on the next cycle
    p_en_flip_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel && reg_wr && reg_addr == OFS_CTRL && reg_wdata[EN_BIT] != en) |=> !ready);
    // R7: a write to the invalidate-all offset drops ready
    p_flush_wr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel && reg_wr && reg_addr == OFS_FLUSH) |=> (!ready && bypass));
    // R10: no array write while a sweep is running
    p_no_we_sweep_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |-> !array_we);
endmodule

// File: tb/sim_icache_ctl.sv
module sim_icache_ctl;
    localparam int CLK_PERIOD = 10;
    localparam int LINES = 64;
    localparam int IW = $clog2(LINES);
    localparam logic [31:0] EXP_ID = 32'h0000_1483;  // (5<<10)|(2<<6)|3
    localparam logic [31:0] EXP_SZ = 32'h0004_0008;
    localparam int NVEC = 7;
    localparam logic [43:0] VEC [NVEC] = '{
        {12'h000, EXP_ID},        // R1
        {12'h004, EXP_SZ},        // R2
        {12'h100, 32'h0001_0000}, // R3: en=0, ready=1
        {12'h700, 32'h0},         // R4
        {12'h008, 32'h0},         // R4
        {12'h104, 32'h0},         // R4
        {12'hFFC, 32'h0}          // R4
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic reg_sel = 1'b0, reg_wr = 1'b0, refill_we_in = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic clr_en, array_we, bypass;
    logic [IW-1:0] clr_idx;
    int errors = 0, checks = 0, cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    icache_ctl #(.NUM_LINES(LINES), .REL_NUM(6'd3), .PART_NUM(4'd2), .CACHE_ID(6'd5),
                 .CACHE_KB(16'd8), .MEM_UNITS(16'd4)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .clr_en(clr_en), .clr_idx(clr_idx), .refill_we_in(refill_we_in),
        .array_we(array_we), .bypass(bypass));

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_sel = 1'b1; reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_sel = 1'b0; reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_sel = 1'b1; reg_wr = 1'b0; reg_addr = a;
        #1 d = reg_rdata;
        reg_sel = 1'b0;
    endtask

    // Called at the negedge where index 0 is being cleared.
    task automatic check_sweep(input string req);
        logic bad = 1'b0;
        logic [31:0] act = '0, exp = '0;
        for (int i = 0; i < LINES; i++) begin
            if (!bad && (clr_en !== 1'b1 || clr_idx !== IW'(i) || bypass !== 1'b1)) begin
                bad = 1'b1; act = {15'd0, clr_en, 16'(clr_idx)}; exp = {15'd0, 1'b1, 16'(i)};
            end
            @(negedge clk);
        end
        if (!bad && (clr_en !== 1'b0 || u0.reg_rdata === 32'hx)) begin
            bad = 1'b1; act = {31'd0, clr_en}; exp = '0;
        end
        check({req, " sweep"}, {31'd0, bad}, exp == exp ? 32'd0 : 32'd0);
        if (bad) $display("     sweep detail %s actual=%h expected=%h", req, act, exp);
    endtask

    logic [31:0] d;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R5 reset ready", {31'd0, u0.clr_en}, 32'd1);
        check("R9 reset bypass", {31'd0, bypass}, 32'd1);
        check_sweep("R5");
        rd(12'h100, d); check("R5 ready after sweep", d, 32'h0001_0000);

        for (int v = 0; v < NVEC; v++) begin
            rd(VEC[v][43:32], d);
            check("R1-4 table R1 R2 R3 R4", d, VEC[v][31:0]);
        end

        wr(12'h000, 32'hFFFF_FFFF);
        #1 check("R1 ident write no sweep", {31'd0, clr_en}, 32'd0);
        rd(12'h000, d); check("R1 ident unchanged", d, EXP_ID);
        wr(12'h004, 32'hFFFF_FFFF);
        rd(12'h004, d); check("R2 size unchanged", d, EXP_SZ);

        wr(12'h100, 32'hFFFE_FFFE);
        #1 check("R6 same enable no sweep", {31'd0, clr_en}, 32'd0);
        check("R9 en=0 ready=1 bypass", {31'd0, bypass}, 32'd1);
        refill_we_in = 1'b1;
        #1 check("R10 gated when en=0", {31'd0, array_we}, 32'd0);

        wr(12'h100, 32'hFFFF_FFFF);
        #1 check("R6 flip starts sweep", {clr_en, 15'd0, 16'(clr_idx)}, 32'h8000_0000);
        check("R10 gated during sweep", {31'd0, array_we}, 32'd0);
        rd(12'h100, d); check("R3 ready low, en set", d, 32'h0000_0001);
        repeat (LINES + 2) @(negedge clk);
        rd(12'h100, d); check("R3 ready high, en set", d, 32'h0001_0001);
        #1 check("R9 en=1 ready=1 no bypass", {31'd0, bypass}, 32'd0);
        check("R10 pass-through", {31'd0, array_we}, 32'd1);

        wr(12'h700, 32'h0);
        #1 check("R7 flush write", {31'd0, bypass, array_we}, 32'd2);
        check_sweep("R7");

        wr(12'h700, 32'h1234_5678);
        repeat (10) @(negedge clk);
        #1 check("R8 mid index", 32'(clr_idx), 32'd10);
        wr(12'h100, 32'h0);
        #1 check("R8 restart at 0", {clr_en, 15'd0, 16'(clr_idx)}, 32'h8000_0000);
        check_sweep("R8");
        #1 check("R9 en=0 after restart", {31'd0, bypass, array_we}, 32'd2);

        wr(12'h100, 32'h1);
        repeat (LINES + 2) @(negedge clk);
        rst_n = 1'b0;
        #1 check("R5 reset mid-run", {30'd0, clr_en, bypass}, 32'd3);
        rd(12'h100, d); check("R3 enable reset value", d, 32'h0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000) begin
                errors++; checks++;
                $display("FAIL watchdog actual=%0d expected<=20000", cycles);
                $display("Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        end
    end
endmodule